// File: doc/BRIEF.md
# Prescaled Tick Counter

This block keeps time by counting a slow tick-enable, nominally 4096 pulses per second, that arrives in the system clock domain. A power-of-two divider picks how many ticks make one step of a 32-bit time counter. Codes 0 through 12 give step rates from 4096 Hz down to 1 Hz. A second, smaller power of two sets a periodic sub-step event. It fires whenever the low bits of the divider counter chosen by a mask code are all zero after a tick. This gives the host regular interrupts finer than one time-counter step.

Software reaches the block through a simple register port. A write is a one-cycle strobe, and a read is combinational from the read address. Alarm comparators and oscillator trimming sit in neighbouring blocks. Their hit pulses come in as event inputs, and each one sets its own sticky flag. Every flag can raise the single interrupt line through its own enable bit. A status bit stays high while a write is still being settled, and it clears after two tick-enable pulses.

Top module: `rtcp_tick_timer`

## Requirements
- R1: After reset every register reads zero (run bit, count, divider code, mask code, flags, interrupt enables, status) and irq is low; addresses are 0 control (bit 0 = run), 1 count, 2 divider code, 3 mask code, 4 flags, 5 interrupt enables, 6 status (bit 0 = pending), 7 reads zero.
- R2: With divider code N (0..12) the count advances by one on the 2^N-th tick-enable pulse of each period, and only on tick pulses while the run bit is set.
- R3: Clearing the run bit freezes the count and the divider counter; setting it again continues from the frozen values with no restart.
- R4: A write to address 1 loads the written value into the count on the next edge, taking priority over a step in the same cycle.
- R5: Flag bit 2 sets on every running tick after which (divider counter AND (2^M - 1)) equals zero, M being the mask code.
- R6: A mask code greater than the current divider code is rejected and the old mask kept; a divider code above 12 is rejected and the old code kept; an accepted divider code below the current mask code lowers the mask to the same value.
- R7: An accepted write to address 2 zeroes the divider counter, so the first step after it takes a full 2^N ticks.
- R8: When the count steps from all ones to zero, flag bit 3 sets.
- R9: Flags at address 4 are sticky and cleared by writing ones; zero bits in the write leave flags untouched; input pulses cmp0_hit, cmp1_hit and trim_hit set bits 0, 1 and 4; a set in the same cycle as its clear wins.
- R10: irq is high exactly when some flag bit and its enable bit at address 5 are both set.
- R11: A write to address 0, 1, 2, 3 or 4, whether accepted or not, makes status bit 0 read one until two further tick-enable pulses have passed; a write to address 5 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle base tick pulse (nominally 4096 Hz) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| cmp0_hit | input | 1 | Event pulse from first alarm comparator |
| cmp1_hit | input | 1 | Event pulse from second alarm comparator |
| trim_hit | input | 1 | Event pulse from trim logic |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch several invariants on every cycle. The mask code never exceeds the divider code, and the divider code never goes past its maximum. A step happens only on a running tick. A count load lands on the next edge, and a stopped count holds. A wrap always leaves the overflow flag set, and a count write always raises pending. Other behaviour depends on exact tick counts and on sequences of writes, and only the bench scenarios show it. This covers the step period for each divider code, where the sub-step flag falls, the restart of the period after a divider change, rejection and clamping of codes, write-one-to-clear with set priority, interrupt masking, and the two-tick life of pending.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned FLAG_N = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_COUNT  = 3'd1,
    REG_DIV    = 3'd2,
    REG_MASK   = 3'd3,
    REG_FLAGS  = 3'd4,
    REG_IRQEN  = 3'd5,
    REG_STATUS = 3'd6
  } reg_sel_e;

  // Flag bit positions (software decodes these)
  localparam int unsigned FL_CMP0   = 0;
  localparam int unsigned FL_CMP1   = 1;
  localparam int unsigned FL_PMATCH = 2;
  localparam int unsigned FL_WRAP   = 3;
  localparam int unsigned FL_TRIM   = 4;
endpackage

// File: rtl/rtcp_prescaler.sv
module rtcp_prescaler #(
  parameter int unsigned PRE_W = 12,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_code,
  input  logic [DIV_W-1:0] mask_code,
  output logic             step,
  output logic             match
);
  localparam logic [PRE_W-1:0] ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] pcnt_q, pcnt_d, pcnt_inc;
  logic [PRE_W-1:0] div_mask, cmp_mask;
  logic             adv, pcnt_en;

  always_comb begin
    div_mask = ~({PRE_W{1'b1}} << div_code);
    cmp_mask = ~({PRE_W{1'b1}} << mask_code);
    adv      = tick & run & ~restart;
    pcnt_inc = pcnt_q + ONE;
    // step on the last tick of a 2^N period
    step     = adv & ((pcnt_q & div_mask) == div_mask);
    // sub-step event: masked bits are zero once the tick is taken
    match    = adv & ((pcnt_inc & cmp_mask) == '0);
    pcnt_en  = restart | adv;
    pcnt_d   = restart ? '0 : pcnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/rtcp_counter.sv
module rtcp_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | step;
    cnt_d  = load ? load_val : (cnt_q + ONE);
    wrap   = step & ~load & (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rtcp_csr.sv
module rtcp_csr
  import rtcp_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned DIV_W      = 4,
  parameter int unsigned MAX_DIV    = 12,
  parameter int unsigned PEND_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              match,
  input  logic              wrap,
  input  logic              evt_cmp0,
  input  logic              evt_cmp1,
  input  logic              evt_trim,
  output logic [CNT_W-1:0]  rd_data,
  output logic              run,
  output logic [DIV_W-1:0]  div_code,
  output logic [DIV_W-1:0]  mask_code,
  output logic              div_restart,
  output logic              load,
  output logic              pending,
  output logic [FLAG_N-1:0] flags,
  output logic [FLAG_N-1:0] irqen,
  output logic              irq
);
  localparam int unsigned      PEND_W    = $clog2(PEND_TICKS + 1);
  localparam logic [CNT_W-1:0] DIV_LIMIT = CNT_W'(MAX_DIV);
  localparam logic [PEND_W-1:0] PEND_LD  = PEND_W'(PEND_TICKS);
  localparam logic [PEND_W-1:0] PEND_ONE = {{(PEND_W-1){1'b0}}, 1'b1};

  logic              run_q;
  logic [DIV_W-1:0]  div_q, mask_q, mask_d, new_code;
  logic [FLAG_N-1:0] flags_q, flags_d, set_vec, clr_vec;
  logic [FLAG_N-1:0] irqen_q;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              hit_ctrl, hit_count, hit_div, hit_mask, hit_flags, hit_irqen;
  logic              div_acc, mask_acc, mask_en, pend_en;

  // write decode
  always_comb begin
    hit_ctrl  = wr_en && (wr_addr == REG_CTRL);
    hit_count = wr_en && (wr_addr == REG_COUNT);
    hit_div   = wr_en && (wr_addr == REG_DIV);
    hit_mask  = wr_en && (wr_addr == REG_MASK);
    hit_flags = wr_en && (wr_addr == REG_FLAGS);
    hit_irqen = wr_en && (wr_addr == REG_IRQEN);
    new_code  = wr_data[DIV_W-1:0];
    div_acc   = hit_div  && (wr_data <= DIV_LIMIT);
    mask_acc  = hit_mask && (wr_data <= CNT_W'(div_q));
  end

  // next-state
  always_comb begin
    mask_en = 1'b0;
    mask_d  = mask_q;
    if (mask_acc) begin
      mask_en = 1'b1;
      mask_d  = new_code;
    end else if (div_acc && (new_code < mask_q)) begin
      mask_en = 1'b1;
      mask_d  = new_code;
    end

    set_vec            = '0;
    set_vec[FL_CMP0]   = evt_cmp0;
    set_vec[FL_CMP1]   = evt_cmp1;
    set_vec[FL_PMATCH] = match;
    set_vec[FL_WRAP]   = wrap;
    set_vec[FL_TRIM]   = evt_trim;
    clr_vec            = hit_flags ? wr_data[FLAG_N-1:0] : '0;
    flags_d            = (flags_q & ~clr_vec) | set_vec;

    pend_en = 1'b0;
    pend_d  = pend_q;
    if (hit_ctrl || hit_count || hit_div || hit_mask || hit_flags) begin
      pend_en = 1'b1;
      pend_d  = PEND_LD;
    end else if (tick && (pend_q != '0)) begin
      pend_en = 1'b1;
      pend_d  = pend_q - PEND_ONE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (hit_ctrl) run_q <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (div_acc) div_q <= new_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irqen_q <= '0;
    else if (hit_irqen) irqen_q <= wr_data[FLAG_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  // read mux
  always_comb begin
    unique case (rd_addr)
      REG_CTRL:   rd_data = CNT_W'(run_q);
      REG_COUNT:  rd_data = count;
      REG_DIV:    rd_data = CNT_W'(div_q);
      REG_MASK:   rd_data = CNT_W'(mask_q);
      REG_FLAGS:  rd_data = CNT_W'(flags_q);
      REG_IRQEN:  rd_data = CNT_W'(irqen_q);
      REG_STATUS: rd_data = CNT_W'(pend_q != '0);
      default:    rd_data = '0;
    endcase
  end

  assign run         = run_q;
  assign div_code    = div_q;
  assign mask_code   = mask_q;
  assign div_restart = div_acc;
  assign load        = hit_count;
  assign pending     = (pend_q != '0);
  assign flags       = flags_q;
  assign irqen       = irqen_q;
  assign irq         = |(flags_q & irqen_q);
endmodule

// File: rtl/rtcp_tick_timer.sv
module rtcp_tick_timer
  import rtcp_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned PRE_W      = 12,
  parameter int unsigned PEND_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cmp0_hit,
  input  logic              cmp1_hit,
  input  logic              trim_hit,
  output logic              irq
);
  localparam int unsigned DIV_W   = $clog2(PRE_W + 1);
  localparam int unsigned MAX_DIV = PRE_W;

  logic [1:0]        rs_q;
  logic              rst_n_s;
  logic              run_w, restart_w, load_w, step_w, match_w, wrap_w, pend_w;
  logic [DIV_W-1:0]  div_w, mask_w;
  logic [CNT_W-1:0]  count_w;
  logic [FLAG_N-1:0] flags_w, irqen_w;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  rtcp_csr #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .MAX_DIV(MAX_DIV), .PEND_TICKS(PEND_TICKS)
  ) u_csr (
    .clk(clk), .rst_n(rst_n_s), .tick(tick_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .count(count_w), .match(match_w), .wrap(wrap_w),
    .evt_cmp0(cmp0_hit), .evt_cmp1(cmp1_hit), .evt_trim(trim_hit),
    .rd_data(rd_data), .run(run_w), .div_code(div_w), .mask_code(mask_w),
    .div_restart(restart_w), .load(load_w), .pending(pend_w),
    .flags(flags_w), .irqen(irqen_w), .irq(irq)
  );

  rtcp_prescaler #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .tick(tick_en), .run(run_w),
    .restart(restart_w), .div_code(div_w), .mask_code(mask_w),
    .step(step_w), .match(match_w)
  );

  rtcp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .step(step_w), .load(load_w),
    .load_val(wr_data), .count(count_w), .wrap(wrap_w)
  );
endmodule

// File: rtl/rtcp_tick_timer_chk.sv
module rtcp_tick_timer_chk
  import rtcp_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned MAX_DIV = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              run,
  input logic              load,
  input logic [CNT_W-1:0]  load_val,
  input logic [CNT_W-1:0]  count,
  input logic              step,
  input logic              wrap,
  input logic [DIV_W-1:0]  div_code,
  input logic [DIV_W-1:0]  mask_code,
  input logic [FLAG_N-1:0] flags,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              pending
);
  p_mask_le_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_code <= div_code);

  p_div_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(div_code) <= MAX_DIV);

  p_step_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (tick && run));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));

  p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[FL_WRAP]);

  p_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == REG_COUNT)) |=> pending);
endmodule

bind rtcp_tick_timer rtcp_tick_timer_chk #(
  .CNT_W(CNT_W), .DIV_W(DIV_W), .MAX_DIV(MAX_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .tick(tick_en), .run(run_w), .load(load_w),
  .load_val(wr_data), .count(count_w), .step(step_w), .wrap(wrap_w),
  .div_code(div_w), .mask_code(mask_w), .flags(flags_w),
  .wr_en(wr_en), .wr_addr(wr_addr), .pending(pend_w)
);

// File: tb/sim_rtcp_tick_timer.sv
`timescale 1ns/1ps
module sim_rtcp_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cmp0_hit = 1'b0, cmp1_hit = 1'b0, trim_hit = 1'b0;
  logic        irq;

  int errors = 0;
  int total  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  typedef struct {
    int          kind;   // 0: rd_data, 1: irq
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  rtcp_tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp0_hit(cmp0_hit), .cmp1_hit(cmp1_hit), .trim_hit(trim_hit), .irq(irq)
  );

  // monitor: pops expected items and compares after each edge settles
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        it  = q.pop_front();
        act = (it.kind == 1) ? {31'b0, irq} : rd_data;
        total++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rd_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #2;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.kind = 1; it.exp = {31'b0, e}; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_reg(3'd0, 32'h0, "R1 ctrl");
    chk_reg(3'd1, 32'h0, "R1 count");
    chk_reg(3'd2, 32'h0, "R1 div");
    chk_reg(3'd4, 32'h0, "R1 flags");
    chk_reg(3'd6, 32'h0, "R1 status");
    chk_reg(3'd7, 32'h0, "R1 unused");
    chk_irq(1'b0, "R1 irq");

    // R4 load, R11 pending lasts two ticks
    wr(3'd1, 32'd5);
    chk_reg(3'd1, 32'd5, "R4 load");
    chk_reg(3'd6, 32'd1, "R11 pending after write");
    ticks(1);
    chk_reg(3'd6, 32'd1, "R11 pending after one tick");
    ticks(1);
    chk_reg(3'd6, 32'd0, "R11 pending after two ticks");
    chk_reg(3'd1, 32'd5, "R3 stopped count holds");

    // R6 code checks
    wr(3'd5, 32'h1F);
    wr(3'd2, 32'd3);
    wr(3'd3, 32'd5);
    chk_reg(3'd3, 32'd0, "R6 mask above div rejected");
    wr(3'd3, 32'd2);
    chk_reg(3'd3, 32'd2, "R6 mask accepted");
    wr(3'd2, 32'd13);
    chk_reg(3'd2, 32'd3, "R6 div above 12 rejected");

    // R2/R5 div 3 (8 ticks), mask 2 (match every 4)
    wr(3'd0, 32'd1);
    ticks(7);
    chk_reg(3'd1, 32'd5, "R2 no step before 8 ticks");
    chk_reg(3'd4, 32'h04, "R5 prescale match flag");
    chk_irq(1'b1, "R10 irq enabled flag");
    ticks(1);
    chk_reg(3'd1, 32'd6, "R2 step on 8th tick");

    // R9 write-one-to-clear
    wr(3'd4, 32'h08);
    chk_reg(3'd4, 32'h04, "R9 zero bits untouched");
    wr(3'd4, 32'h04);
    chk_reg(3'd4, 32'h00, "R9 cleared");
    chk_irq(1'b0, "R10 irq low with no flags");

    // R3 stop/resume
    wr(3'd0, 32'd0);
    ticks(20);
    chk_reg(3'd1, 32'd6, "R3 frozen while stopped");
    wr(3'd0, 32'd1);
    ticks(7);
    chk_reg(3'd1, 32'd6, "R3 resume no early step");
    ticks(1);
    chk_reg(3'd1, 32'd7, "R3 resume continues period");

    // R7 divider restart
    ticks(3);
    wr(3'd2, 32'd2);
    chk_reg(3'd3, 32'd2, "R6 equal mask kept");
    ticks(3);
    chk_reg(3'd1, 32'd7, "R7 no step before full period");
    ticks(1);
    chk_reg(3'd1, 32'd8, "R7 step after full period");

    // R8 wrap, R6 clamp, R10 masking
    wr(3'd1, 32'hFFFF_FFFF);
    chk_reg(3'd1, 32'hFFFF_FFFF, "R4 load all ones");
    wr(3'd2, 32'd0);
    chk_reg(3'd3, 32'd0, "R6 mask lowered with div");
    wr(3'd4, 32'h1F);
    chk_reg(3'd4, 32'h00, "R9 clear all");
    ticks(1);
    chk_reg(3'd1, 32'h0, "R8 count wrapped");
    chk_reg(3'd4, 32'h0C, "R8 overflow and match flags");
    wr(3'd5, 32'h08);
    chk_irq(1'b1, "R10 overflow enabled");
    wr(3'd4, 32'h08);
    chk_irq(1'b0, "R10 match flag not enabled");

    // R9 event inputs and set priority
    wr(3'd0, 32'd0);
    @(negedge clk);
    cmp1_hit = 1'b1; trim_hit = 1'b1;
    @(negedge clk);
    cmp1_hit = 1'b0; trim_hit = 1'b0;
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h01; cmp0_hit = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cmp0_hit = 1'b0;
    chk_reg(3'd4, 32'h17, "R9 events set, set beats clear");

    // R11 interrupt-enable writes leave pending alone
    ticks(2);
    chk_reg(3'd6, 32'd0, "R11 pending idle");
    wr(3'd5, 32'h00);
    chk_reg(3'd6, 32'd0, "R11 irqen write no pending");
    wr(3'd3, 32'd7);
    chk_reg(3'd6, 32'd1, "R11 rejected mask write pending");
    ticks(2);
    chk_reg(3'd6, 32'd0, "R11 pending done");

    // R2 slowest code
    wr(3'd1, 32'h100);
    wr(3'd2, 32'd12);
    wr(3'd0, 32'd1);
    ticks(4095);
    chk_reg(3'd1, 32'h100, "R2 code 12 before 4096 ticks");
    ticks(1);
    chk_reg(3'd1, 32'h101, "R2 code 12 step");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule